// File: doc/BRIEF.md
# Tree Pseudo-LRU Way Selector

This block holds the replacement state of a set-associative cache with 2 or 4 ways. Each set owns three state bits that are shared by all of its ways. A bit 0 at the root chooses between the way pair {0,1} and the way pair {2,3}. Two leaf bits then choose a way inside each pair. Every cycle the block names a victim way for the set on the lookup port. It updates a set's bits when an access (hit or fill) to a given way is reported. A flush returns every set to the all-zero state.

A diagnostic port can read the raw three bits of any set. It can also overwrite them in a single cycle, so that test software can preload or inspect the replacement state. The tag compare and the data arrays sit outside this block. The state lives in flops with a synchronous active-high reset. Both outputs are registered.

Top module: `plru_tree_sel`

## Requirements
- R1: After reset every set holds 3'b000, and both `victim_way_o` and `dbg_bits_o` read 0.
- R2: State bit 0 is the root: 0 selects ways 0/1 and 1 selects ways 2/3. Bit 1 selects way 0 (0) or way 1 (1). Bit 2 selects way 2 (0) or way 3 (1). `victim_way_o` is registered, so one cycle after `lookup_set_i` is sampled it names the way those bits point at. It uses the bits as they stood at that edge, before any update in the same cycle.
- R3: In 4-way mode, an access to way w (`acc_valid_i`=1) sets the root to point at the other pair. It sets the leaf of w's pair to point at the other way of that pair. The leaf of the other pair is unchanged.
- R4: In 2-way mode (WAYS=2) only bit 0 is live and it selects way 0 (0) or way 1 (1). Bit 1 of `acc_way_i` has no effect. `victim_way_o[1]` is always 0, and bits 2:1 of every set stay 0.
- R5: A diagnostic write (`dbg_wr_i`) replaces the bits of set `dbg_set_i` with `dbg_bits_i` at the next edge. In 2-way mode bits 2:1 are stored as 0.
- R6: A diagnostic read (`dbg_rd_i`) loads the set's bits, as they stood at that edge, into `dbg_bits_o` one cycle later. Without a read, `dbg_bits_o` holds its value.
- R7: If an access and a diagnostic write address the same set in the same cycle, the set takes the diagnostic value. If they address different sets, both take effect.
- R8: `flush_i` clears all sets to 3'b000 at the next edge. It overrides any access or diagnostic write in the same cycle.
- R9: A way that has just been accessed is never the victim that is next reported for that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Clear the state of all sets |
| lookup_set_i | input | SET_W | Set whose victim is wanted |
| victim_way_o | output | 2 | Registered victim way |
| acc_valid_i | input | 1 | Access (hit or fill) report |
| acc_set_i | input | SET_W | Set of the access |
| acc_way_i | input | 2 | Way of the access |
| dbg_wr_i | input | 1 | Diagnostic write strobe |
| dbg_rd_i | input | 1 | Diagnostic read strobe |
| dbg_set_i | input | SET_W | Set addressed by the diagnostic port |
| dbg_bits_i | input | 3 | Raw bits to write |
| dbg_bits_o | output | 3 | Registered raw bits read back |

## Verification
The assertions check the following on every cycle:
- The 2-way output and read-back masking.
- The reset and flush results.
- That a just-accessed way is never the next victim.
- That a diagnostic write is returned by a read that immediately follows it.

The exact tree update, the unchanged leaf on the other side, and the conflict priorities need specific sequences to show. The same holds for victim decoding from preloaded patterns. The bench drives those sequences and compares both a 4-way and a 2-way instance against a behavioural model on every clock.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int PLRU_BITS = 3;
  typedef logic [PLRU_BITS-1:0] plru_bits_t;
  typedef logic [1:0]           way_t;

  // bits that carry state for a given associativity
  function automatic plru_bits_t live_mask(input int ways);
    return (ways == 4) ? 3'b111 : 3'b001;
  endfunction
endpackage

// File: rtl/plru_victim_dec.sv
module plru_victim_dec
  import plru_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  plru_bits_t bits_i,
  output way_t       way_o
);
  generate
    if (WAYS == 4) begin : g_four
      always_comb begin
        if (bits_i[0]) way_o = {1'b1, bits_i[2]};
        else           way_o = {1'b0, bits_i[1]};
      end
    end else begin : g_two
      always_comb way_o = {1'b0, bits_i[0]};
    end
  endgenerate
endmodule

// File: rtl/plru_touch_upd.sv
module plru_touch_upd
  import plru_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  plru_bits_t cur_i,
  input  way_t       way_i,
  output plru_bits_t nxt_o
);
  generate
    if (WAYS == 4) begin : g_four
      always_comb begin
        nxt_o    = cur_i;
        nxt_o[0] = ~way_i[1];
        if (way_i[1]) nxt_o[2] = ~way_i[0];
        else          nxt_o[1] = ~way_i[0];
      end
    end else begin : g_two
      always_comb nxt_o = {2'b00, ~way_i[0]};
    end
  endgenerate
endmodule

// File: rtl/plru_state_regs.sv
module plru_state_regs
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             upd_en_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  plru_bits_t       upd_bits_i,
  input  logic             dw_en_i,
  input  logic [SET_W-1:0] dw_set_i,
  input  plru_bits_t       dw_bits_i,
  input  logic [SET_W-1:0] ra_set_i,
  output plru_bits_t       ra_bits_o,
  input  logic [SET_W-1:0] rv_set_i,
  output plru_bits_t       rv_bits_o,
  input  logic [SET_W-1:0] rd_set_i,
  output plru_bits_t       rd_bits_o
);
  plru_bits_t st [NUM_SETS];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SETS; s++) begin
      if (rst || clr_i)
        st[s] <= '0;
      else if (dw_en_i && dw_set_i == SET_W'(s))
        st[s] <= dw_bits_i;
      else if (upd_en_i && upd_set_i == SET_W'(s))
        st[s] <= upd_bits_i;
    end
  end

  assign ra_bits_o = st[ra_set_i];
  assign rv_bits_o = st[rv_set_i];
  assign rd_bits_o = st[rd_set_i];
endmodule

// File: rtl/plru_tree_sel.sv
module plru_tree_sel
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int WAYS     = 4,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [SET_W-1:0] lookup_set_i,
  output logic [1:0]       victim_way_o,
  input  logic             acc_valid_i,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic [1:0]       acc_way_i,
  input  logic             dbg_wr_i,
  input  logic             dbg_rd_i,
  input  logic [SET_W-1:0] dbg_set_i,
  input  logic [2:0]       dbg_bits_i,
  output logic [2:0]       dbg_bits_o
);
  localparam plru_bits_t LIVE = live_mask(WAYS);

  plru_bits_t acc_cur, acc_nxt, vic_bits, rd_bits;
  way_t       vic_way;

  plru_state_regs #(.NUM_SETS(NUM_SETS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (flush_i),
    .upd_en_i  (acc_valid_i),
    .upd_set_i (acc_set_i),
    .upd_bits_i(acc_nxt),
    .dw_en_i   (dbg_wr_i),
    .dw_set_i  (dbg_set_i),
    .dw_bits_i (dbg_bits_i & LIVE),
    .ra_set_i  (acc_set_i),
    .ra_bits_o (acc_cur),
    .rv_set_i  (lookup_set_i),
    .rv_bits_o (vic_bits),
    .rd_set_i  (dbg_set_i),
    .rd_bits_o (rd_bits)
  );

  plru_touch_upd #(.WAYS(WAYS)) u_touch (
    .cur_i(acc_cur),
    .way_i(acc_way_i),
    .nxt_o(acc_nxt)
  );

  plru_victim_dec #(.WAYS(WAYS)) u_vic (
    .bits_i(vic_bits),
    .way_o (vic_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_way_o <= '0;
      dbg_bits_o   <= '0;
    end else begin
      victim_way_o <= vic_way;
      if (dbg_rd_i) dbg_bits_o <= rd_bits;
    end
  end
endmodule

// File: rtl/plru_tree_sel_chk.sv
module plru_tree_sel_chk #(
  parameter int NUM_SETS = 64,
  parameter int WAYS     = 4,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             flush_i,
  input logic [SET_W-1:0] lookup_set_i,
  input logic [1:0]       victim_way_o,
  input logic             acc_valid_i,
  input logic [SET_W-1:0] acc_set_i,
  input logic [1:0]       acc_way_i,
  input logic             dbg_wr_i,
  input logic             dbg_rd_i,
  input logic [SET_W-1:0] dbg_set_i,
  input logic [2:0]       dbg_bits_i,
  input logic [2:0]       dbg_bits_o
);
  localparam logic [2:0] LIVE = (WAYS == 4) ? 3'b111 : 3'b001;
  localparam logic [1:0] WMSK = (WAYS == 4) ? 2'b11 : 2'b01;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (victim_way_o == 2'b00 && dbg_bits_o == 3'b000));

  // R4
  two_way_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (WAYS == 2) |-> (!victim_way_o[1] && dbg_bits_o[2:1] == 2'b00));

  // R8
  flush_victim_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |-> ##2 victim_way_o == 2'b00);

  // R8
  flush_read_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i ##1 dbg_rd_i |=> dbg_bits_o == 3'b000);

  // R5
  diag_roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_wr_i && !flush_i) ##1 (dbg_rd_i && dbg_set_i == $past(dbg_set_i))
      |=> dbg_bits_o == ($past(dbg_bits_i, 2) & LIVE));

  // R9
  no_recent_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && !dbg_wr_i && !flush_i) ##1 (lookup_set_i == $past(acc_set_i))
      |=> (victim_way_o & WMSK) != ($past(acc_way_i, 2) & WMSK));
endmodule

bind plru_tree_sel plru_tree_sel_chk #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst(rst), .flush_i(flush_i), .lookup_set_i(lookup_set_i),
  .victim_way_o(victim_way_o), .acc_valid_i(acc_valid_i), .acc_set_i(acc_set_i),
  .acc_way_i(acc_way_i), .dbg_wr_i(dbg_wr_i), .dbg_rd_i(dbg_rd_i),
  .dbg_set_i(dbg_set_i), .dbg_bits_i(dbg_bits_i), .dbg_bits_o(dbg_bits_o)
);

// File: tb/sim_plru_tree_sel.sv
module sim_plru_tree_sel;
  localparam int NS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush_i = 1'b0;
  logic [3:0] lookup_set_i = '0;
  logic       acc_valid_i = 1'b0;
  logic [3:0] acc_set_i = '0;
  logic [1:0] acc_way_i = '0;
  logic       dbg_wr_i = 1'b0;
  logic       dbg_rd_i = 1'b0;
  logic [3:0] dbg_set_i = '0;
  logic [2:0] dbg_bits_i = '0;
  logic [1:0] vic4, vic2;
  logic [2:0] bits4, bits2;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit armed = 0;

  always #2 clk = ~clk;

  plru_tree_sel #(.NUM_SETS(NS), .WAYS(4)) u0 (
    .clk(clk), .rst(rst), .flush_i(flush_i), .lookup_set_i(lookup_set_i),
    .victim_way_o(vic4), .acc_valid_i(acc_valid_i), .acc_set_i(acc_set_i),
    .acc_way_i(acc_way_i), .dbg_wr_i(dbg_wr_i), .dbg_rd_i(dbg_rd_i),
    .dbg_set_i(dbg_set_i), .dbg_bits_i(dbg_bits_i), .dbg_bits_o(bits4));

  plru_tree_sel #(.NUM_SETS(NS), .WAYS(2)) u1 (
    .clk(clk), .rst(rst), .flush_i(flush_i), .lookup_set_i(lookup_set_i),
    .victim_way_o(vic2), .acc_valid_i(acc_valid_i), .acc_set_i(acc_set_i),
    .acc_way_i(acc_way_i), .dbg_wr_i(dbg_wr_i), .dbg_rd_i(dbg_rd_i),
    .dbg_set_i(dbg_set_i), .dbg_bits_i(dbg_bits_i), .dbg_bits_o(bits2));

  // behavioural reference: ints per set
  int m4 [NS];
  int m2 [NS];
  int ev4 = 0, ev2 = 0, ed4 = 0, ed2 = 0;

  function automatic int pick4(int b);
    int root = b % 2;
    int lo   = (b / 2) % 2;
    int hi   = (b / 4) % 2;
    if (root == 0) return lo;
    return 2 + hi;
  endfunction

  function automatic int touch4(int b, int w);
    int lo = (b / 2) % 2;
    int hi = (b / 4) % 2;
    int root;
    case (w)
      0: begin root = 1; lo = 1; end
      1: begin root = 1; lo = 0; end
      2: begin root = 0; hi = 1; end
      default: begin root = 0; hi = 0; end
    endcase
    return root + 2 * lo + 4 * hi;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin m4[s] = 0; m2[s] = 0; end
      ev4 = 0; ev2 = 0; ed4 = 0; ed2 = 0;
    end else begin
      ev4 = pick4(m4[lookup_set_i]);
      ev2 = m2[lookup_set_i];
      if (dbg_rd_i) begin ed4 = m4[dbg_set_i]; ed2 = m2[dbg_set_i]; end
      if (flush_i) begin
        for (int s = 0; s < NS; s++) begin m4[s] = 0; m2[s] = 0; end
      end else begin
        if (acc_valid_i && !(dbg_wr_i && dbg_set_i == acc_set_i)) begin
          m4[acc_set_i] = touch4(m4[acc_set_i], int'(acc_way_i));
          m2[acc_set_i] = (acc_way_i[0] == 1'b0) ? 1 : 0;
        end
        if (dbg_wr_i) begin
          m4[dbg_set_i] = int'(dbg_bits_i);
          m2[dbg_set_i] = int'(dbg_bits_i[0]);
        end
      end
    end
    armed = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R2 victim 4-way", int'(vic4), ev4);
      chk("R4 victim 2-way", int'(vic2), ev2);
      chk("R6 read-back 4-way", int'(bits4), ed4);
      chk("R6 read-back 2-way", int'(bits2), ed2);
    end
  end

  task automatic idle();
    flush_i = 0; acc_valid_i = 0; dbg_wr_i = 0; dbg_rd_i = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic dwrite(input int s, input int b);
    idle(); dbg_wr_i = 1; dbg_set_i = 4'(s); dbg_bits_i = 3'(b);
    step(); idle();
  endtask

  task automatic access(input int s, input int w);
    idle(); acc_valid_i = 1; acc_set_i = 4'(s); acc_way_i = 2'(w);
    step(); idle();
  endtask

  // read bits and victim of a set; outputs valid one cycle later
  task automatic probe(input int s);
    idle(); dbg_rd_i = 1; dbg_set_i = 4'(s); lookup_set_i = 4'(s);
    step(); idle();
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1
    chk("R1 victim 4-way after reset", int'(vic4), 0);
    chk("R1 read-back after reset", int'(bits4), 0);
    probe(9);
    chk("R1 set bits zero", int'(bits4), 0);

    // R5 R2: preload 111 -> victim way3; 2-way keeps only bit 0
    dwrite(3, 7);
    probe(3);
    chk("R5 stored bits 4-way", int'(bits4), 7);
    chk("R5 stored bits 2-way masked", int'(bits2), 1);
    chk("R2 root=1 hi=1 gives way3", int'(vic4), 3);
    dwrite(4, 2);
    probe(4);
    chk("R2 root=0 lo=1 gives way1", int'(vic4), 1);

    // R3: access way3 on 111 -> 010, victim way1
    access(3, 3);
    probe(3);
    chk("R3 touch way3 keeps other leaf", int'(bits4), 2);
    chk("R3 victim after touch", int'(vic4), 1);
    // R4: way index 3 acts as way1 in 2-way -> bit 0
    chk("R4 upper way bit ignored", int'(bits2), 0);
    chk("R4 victim after touch", int'(vic2), 0);
    access(3, 0);
    probe(3);
    chk("R3 touch way0", int'(bits4), 3);
    chk("R9 touched way not victim", int'(vic4 == 2'd0), 0);

    // R7: same-set conflict, diagnostic value wins
    idle(); acc_valid_i = 1; acc_set_i = 5; acc_way_i = 2;
    dbg_wr_i = 1; dbg_set_i = 5; dbg_bits_i = 3'b011;
    step(); idle();
    probe(5);
    chk("R7 diag write beats access", int'(bits4), 3);
    // R7: different sets both land
    idle(); acc_valid_i = 1; acc_set_i = 6; acc_way_i = 1;
    dbg_wr_i = 1; dbg_set_i = 7; dbg_bits_i = 3'b100;
    step(); idle();
    probe(6);
    chk("R7 access to other set applied", int'(bits4), 1);
    probe(7);
    chk("R7 diag to other set applied", int'(bits4), 4);

    // R6: read-back holds without a read strobe
    lookup_set_i = 0; step(); step();
    chk("R6 read-back holds", int'(bits4), 4);

    // R8: flush beats a simultaneous diagnostic write
    idle(); flush_i = 1; dbg_wr_i = 1; dbg_set_i = 7; dbg_bits_i = 3'b111;
    acc_valid_i = 1; acc_set_i = 3; acc_way_i = 1;
    step(); idle();
    probe(7);
    chk("R8 flush clears written set", int'(bits4), 0);
    probe(3);
    chk("R8 flush clears accessed set", int'(bits4), 0);

    // random traffic, checked each clock by the model
    for (int i = 0; i < 4000; i++) begin
      flush_i      = ($urandom % 97) == 0;
      lookup_set_i = 4'($urandom);
      acc_valid_i  = 1'($urandom);
      acc_set_i    = 4'($urandom % 4);
      acc_way_i    = 2'($urandom);
      dbg_wr_i     = ($urandom % 5) == 0;
      dbg_rd_i     = 1'($urandom);
      dbg_set_i    = 4'($urandom % 4);
      dbg_bits_i   = 3'($urandom);
      step();
    end
    idle();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule